// File: doc/BRIEF.md
# Ethernet Receive Frame Validator

This block sits behind a byte-wide receive interface of the kind a GMII or MII link presents, with a data-valid strobe and an error strobe. It hunts for the run of preamble bytes and the start-of-frame delimiter. It then stores the bytes of the frame, from the first destination address byte through the last check byte, into a local buffer. While it stores them it parses the header, runs the 32-bit Ethernet CRC and counts the length.

When data-valid falls, the block decides whether to keep the frame. The destination address must pass the filter, the length must be legal, no error strobe may have been seen, and the CRC residue must be correct. A kept frame is committed: its bytes then leave in order on a byte stream that marks the last byte, and a one-cycle status word reports the length, the type field, whether a VLAN tag was present, and whether the frame was broadcast or multicast. A rejected frame is discarded by moving the write pointer back to the frame's first byte, so nothing of it ever reaches the output.

Top module: `eth_rx_filter`

## Requirements
- R1: A frame is taken only when the delimiter byte 0xD5 follows at least 7 consecutive preamble bytes of 0x55. A shorter preamble, or any other byte, causes the whole burst to be ignored until data-valid falls.
- R2: The CRC-32 (reflected, polynomial 0x04C11DB7, register preset to all ones) is run over every stored byte including the 4 check bytes, which arrive least significant byte first. A frame whose residue differs from 0xC704DD7B (0xDEBB20E3 in reflected bit order) is rejected.
- R3: The destination address is the first 6 bytes, with the first byte in bits 47:40. The address passes when it equals `station_addr`, is all ones (broadcast), has bit 0 of its first byte set while `mcast_en` is high, or when `promisc` is high.
- R4: The frame length counts bytes from the destination address through the check bytes. It must be at least 64 and at most 1518 (1522 for a tagged frame), otherwise the frame is rejected.
- R5: A frame during which `rx_er` is high on any valid byte after the delimiter is rejected.
- R6: Bytes 12 and 13 equal to 0x81, 0x00 mark a tagged frame. The reported type is then taken from bytes 16 and 17 instead of bytes 12 and 13, and `stat_vlan` is set.
- R7: An accepted frame appears on `out_data` with `out_valid` high, every byte in arrival order, and `out_eof` high with the last check byte only. A rejected frame produces no output byte.
- R8: `stat_valid` pulses for one cycle in the second clock after the last frame byte, which is the clock that samples data-valid low. It pulses only for accepted frames and carries the length, the type, the tag flag, the broadcast flag, and the multicast flag (group bit set and not broadcast).
- R9: While `rst` is high, `out_valid`, `out_eof` and `stat_valid` are low in the following cycle.
- R10: A frame that follows a rejected frame is delivered complete and uncorrupted, because the rejected frame's stored bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_dv | input | 1 | Receive byte valid |
| rx_er | input | 1 | Receive error strobe |
| rx_data | input | 8 | Receive byte |
| station_addr | input | 48 | Own unicast address, first byte in bits 47:40 |
| mcast_en | input | 1 | Accept group-addressed frames |
| promisc | input | 1 | Accept every destination address |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte of an accepted frame |
| out_eof | output | 1 | Last byte of an accepted frame |
| stat_valid | output | 1 | Status word valid, one cycle per accepted frame |
| stat_len | output | LEN_W (11) | Frame length in bytes |
| stat_type | output | 16 | Length/type field |
| stat_vlan | output | 1 | Frame carried a VLAN tag |
| stat_bcast | output | 1 | Destination was broadcast |
| stat_mcast | output | 1 | Destination was multicast |

## Verification
The hardest situation to reach from the ports is a frame that crosses a length limit by a single byte. That byte arrives after more than 1500 payload bytes, and the decision to rewind is taken mid-frame rather than at the frame end. The stimulus builds frames with a correct check sequence at exactly 1518 and 1519 bytes, and tagged at 1522 and 1523 bytes, so that only the length rule can reject them. A rejected frame is always followed by a good one, which shows that the rewind left the buffer clean.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [15:0] TPID_VLAN   = 16'h8100;
  // reflected form of 0x04C11DB7
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  // good-frame residue in reflected bit order (0xC704DD7B in normal order)
  localparam logic [31:0] CRC_GOOD_R  = 32'hDEBB20E3;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PRE,
    S_BODY,
    S_DROP
  } rx_state_t;

endpackage

// File: rtl/eth_crc_byte.sv
module eth_crc_byte #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic [31:0] crc_in,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);

  always_comb begin
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ din[i]) c = (c >> 1) ^ POLY;
      else               c = c >> 1;
    end
    crc_out = c;
  end

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter (
  input  logic [47:0] da,
  input  logic [47:0] station_addr,
  input  logic        mcast_en,
  input  logic        promisc,
  output logic        accept,
  output logic        is_bcast,
  output logic        is_mcast
);

  logic group_bit;

  always_comb begin
    group_bit = da[40];
    is_bcast  = &da;
    is_mcast  = group_bit && !is_bcast;
    accept    = promisc || (da == station_addr) || is_bcast ||
                (group_bit && mcast_en);
  end

endmodule

// File: rtl/eth_frame_buf.sv
module eth_frame_buf #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          flag_we,
  input  logic [AW-1:0] flag_addr,
  input  logic          flag_val,
  input  logic [AW-1:0] commit_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_eof
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] data_mem [DEPTH];
  logic       flag_mem [DEPTH];
  logic       have_data;

  assign have_data = (rd_ptr != commit_ptr);

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (flag_we) flag_mem[flag_addr] <= flag_val;
  end

  always_ff @(posedge clk) begin
    if (have_data) out_data <= data_mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
    end else if (have_data) begin
      rd_ptr    <= rd_ptr + 1'b1;
      out_valid <= 1'b1;
      out_eof   <= flag_mem[rd_ptr];
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rx_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int PRE_MIN    = 7,
  parameter int BUF_DEPTH  = 2048,
  parameter int LEN_W      = $clog2(MAX_LEN + VLAN_EXTRA + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic [7:0]       rx_data,
  input  logic [47:0]      station_addr,
  input  logic             mcast_en,
  input  logic             promisc,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_eof,
  output logic             stat_valid,
  output logic [LEN_W-1:0] stat_len,
  output logic [15:0]      stat_type,
  output logic             stat_vlan,
  output logic             stat_bcast,
  output logic             stat_mcast
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int PW = $clog2(PRE_MIN + 1);
  localparam logic [LEN_W-1:0] L_MIN   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] L_MAX   = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] L_MAXV  = LEN_W'(MAX_LEN + VLAN_EXTRA);
  localparam logic [LEN_W-1:0] L_DA    = LEN_W'(6);
  localparam logic [LEN_W-1:0] L_T0    = LEN_W'(12);
  localparam logic [LEN_W-1:0] L_T1    = LEN_W'(13);
  localparam logic [LEN_W-1:0] L_V0    = LEN_W'(16);
  localparam logic [LEN_W-1:0] L_V1    = LEN_W'(17);
  localparam logic [PW-1:0]    PRE_SAT = PW'(PRE_MIN);

  rx_state_t        state;
  logic [PW-1:0]    pre_cnt;
  logic [AW-1:0]    wr_ptr, start_ptr, commit_ptr, rd_ptr;
  logic [LEN_W-1:0] len, len_cap;
  logic [31:0]      crc, crc_nx;
  logic             bad, vlan;
  logic [47:0]      da;
  logic [7:0]       hold;
  logic [15:0]      ftype;
  logic             filt_ok, is_bc, is_mc;
  logic             byte_in, at_limit, buf_full, take, frame_end, good;
  logic             flag_we, flag_val;
  logic [AW-1:0]    flag_addr;

  eth_crc_byte #(.POLY(CRC_POLY_R)) u_crc (
    .crc_in (crc),
    .din    (rx_data),
    .crc_out(crc_nx)
  );

  eth_da_filter u_filt (
    .da          (da),
    .station_addr(station_addr),
    .mcast_en    (mcast_en),
    .promisc     (promisc),
    .accept      (filt_ok),
    .is_bcast    (is_bc),
    .is_mcast    (is_mc)
  );

  always_comb begin
    byte_in   = (state == S_BODY) && rx_dv;
    len_cap   = vlan ? L_MAXV : L_MAX;
    at_limit  = (len == len_cap);
    buf_full  = (AW'(wr_ptr + 1'b1) == rd_ptr);
    take      = byte_in && !at_limit && !buf_full;
    frame_end = (state == S_BODY) && !rx_dv;
    good      = frame_end && !bad && (len >= L_MIN) &&
                (crc == CRC_GOOD_R) && filt_ok;
    flag_we   = take || good;
    flag_val  = !take;
    flag_addr = take ? wr_ptr : AW'(wr_ptr - 1'b1);
  end

  eth_frame_buf #(.AW(AW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (take),
    .wr_addr   (wr_ptr),
    .wr_data   (rx_data),
    .flag_we   (flag_we),
    .flag_addr (flag_addr),
    .flag_val  (flag_val),
    .commit_ptr(commit_ptr),
    .rd_ptr    (rd_ptr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eof   (out_eof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pre_cnt    <= '0;
      wr_ptr     <= '0;
      start_ptr  <= '0;
      commit_ptr <= '0;
      len        <= '0;
      crc        <= '1;
      bad        <= 1'b0;
      vlan       <= 1'b0;
      da         <= '0;
      hold       <= '0;
      ftype      <= '0;
      stat_valid <= 1'b0;
      stat_len   <= '0;
      stat_type  <= '0;
      stat_vlan  <= 1'b0;
      stat_bcast <= 1'b0;
      stat_mcast <= 1'b0;
    end else begin
      stat_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          start_ptr <= wr_ptr;
          if (rx_dv) begin
            if (!rx_er && rx_data == PRE_BYTE) begin
              state   <= S_PRE;
              pre_cnt <= PW'(1);
            end else begin
              state <= S_DROP;
            end
          end
        end
        S_PRE: begin
          if (!rx_dv) begin
            state <= S_IDLE;
          end else if (rx_er) begin
            state <= S_DROP;
          end else if (rx_data == PRE_BYTE) begin
            if (pre_cnt != PRE_SAT) pre_cnt <= pre_cnt + 1'b1;
          end else if (rx_data == SFD_BYTE && pre_cnt == PRE_SAT) begin
            state <= S_BODY;
            len   <= '0;
            crc   <= '1;
            bad   <= 1'b0;
            vlan  <= 1'b0;
            da    <= '0;
          end else begin
            state <= S_DROP;
          end
        end
        S_BODY: begin
          if (rx_dv) begin
            if (take) begin
              wr_ptr <= wr_ptr + 1'b1;
              len    <= len + 1'b1;
              crc    <= crc_nx;
              if (rx_er) bad <= 1'b1;
              if (len < L_DA) da <= {da[39:0], rx_data};
              if (len == L_T0 || (vlan && len == L_V0)) hold <= rx_data;
              if (len == L_T1) begin
                vlan  <= ({hold, rx_data} == TPID_VLAN);
                ftype <= {hold, rx_data};
              end
              if (vlan && len == L_V1) ftype <= {hold, rx_data};
            end else begin
              state  <= S_DROP;
              wr_ptr <= start_ptr;
            end
          end else begin
            state <= S_IDLE;
            if (good) begin
              commit_ptr <= wr_ptr;
              stat_valid <= 1'b1;
              stat_len   <= len;
              stat_type  <= ftype;
              stat_vlan  <= vlan;
              stat_bcast <= is_bc;
              stat_mcast <= is_mc;
            end else begin
              wr_ptr <= start_ptr;
            end
          end
        end
        S_DROP: begin
          if (!rx_dv) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int LEN_W      = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_dv,
  input logic             out_valid,
  input logic             out_eof,
  input logic             stat_valid,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_vlan,
  input logic             stat_bcast,
  input logic             stat_mcast
);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_eof && !stat_valid));

  a_r7_eof_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);

  a_r8_stat_after_dv_fall: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (!$past(rx_dv) && $past(rx_dv, 2)));

  a_r8_stat_one_cycle: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);

  a_r4_len_legal: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (int'(stat_len) >= MIN_LEN &&
                    int'(stat_len) <= MAX_LEN + (stat_vlan ? VLAN_EXTRA : 0)));

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> !(stat_bcast && stat_mcast));

endmodule

bind eth_rx_filter eth_rx_filter_chk #(
  .MIN_LEN   (MIN_LEN),
  .MAX_LEN   (MAX_LEN),
  .VLAN_EXTRA(VLAN_EXTRA),
  .LEN_W     (LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_dv     (rx_dv),
  .out_valid (out_valid),
  .out_eof   (out_eof),
  .stat_valid(stat_valid),
  .stat_len  (stat_len),
  .stat_vlan (stat_vlan),
  .stat_bcast(stat_bcast),
  .stat_mcast(stat_mcast)
);

// File: tb/sim_eth_rx_filter.sv
`timescale 1ns/1ps
module sim_eth_rx_filter;

  localparam logic [47:0] STN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] SRC   = 48'h0A_0B_0C_0D_0E_0F;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_dv, rx_er;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic        mcast_en, promisc;
  logic        out_valid, out_eof, stat_valid;
  logic [7:0]  out_data;
  logic [10:0] stat_len;
  logic [15:0] stat_type;
  logic        stat_vlan, stat_bcast, stat_mcast;

  always #2.5 clk = ~clk;

  eth_rx_filter u0 (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rx_data(rx_data),
    .station_addr(station_addr), .mcast_en(mcast_en), .promisc(promisc),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_type(stat_type),
    .stat_vlan(stat_vlan), .stat_bcast(stat_bcast), .stat_mcast(stat_mcast)
  );

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  logic [7:0] fq[$];
  logic [7:0] eq[$];
  bit         eeof[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic build(logic [47:0] dst, bit tag, logic [15:0] typ, int plen, bit corrupt);
    logic [31:0] c;
    fq.delete();
    for (int i = 0; i < 6; i++) fq.push_back(dst[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fq.push_back(SRC[47-8*i -: 8]);
    if (tag) begin
      fq.push_back(8'h81); fq.push_back(8'h00);
      fq.push_back(8'h20); fq.push_back(8'h07);
    end
    fq.push_back(typ[15:8]); fq.push_back(typ[7:0]);
    for (int i = 0; i < plen; i++) fq.push_back(8'((i * 13 + plen) & 255));
    c = 32'hFFFF_FFFF;
    foreach (fq[i]) c = crc_step(c, fq[i]);
    c = ~c;
    if (corrupt) c[3] = ~c[3];
    for (int i = 0; i < 4; i++) fq.push_back(c[8*i +: 8]);
  endtask

  task automatic send(int npre, int er_at, string req);
    int len, maxl, t;
    bit vl, bc, mc, crc_ok, addr_ok, acc;
    logic [47:0] d;
    logic [31:0] c, fcs;
    logic [15:0] typ;
    len = fq.size();
    vl  = (len >= 18) && fq[12] == 8'h81 && fq[13] == 8'h00;
    maxl = vl ? 1522 : 1518;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len - 4; i++) c = crc_step(c, fq[i]);
    fcs = {fq[len-1], fq[len-2], fq[len-3], fq[len-4]};
    crc_ok = (~c == fcs);
    d = {fq[0], fq[1], fq[2], fq[3], fq[4], fq[5]};
    bc = (d == BCAST);
    mc = d[40] && !bc;
    addr_ok = promisc || d == station_addr || bc || (d[40] && mcast_en);
    acc = (npre >= 7) && (er_at < 0) && len >= 64 && len <= maxl && crc_ok && addr_ok;
    typ = vl ? {fq[16], fq[17]} : {fq[12], fq[13]};
    if (acc)
      for (int i = 0; i < len; i++) begin
        eq.push_back(fq[i]);
        eeof.push_back(i == len - 1);
      end
    for (int i = 0; i < npre; i++) begin
      @(negedge clk); rx_dv = 1; rx_er = 0; rx_data = 8'h55;
    end
    @(negedge clk); rx_data = 8'hD5;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_data = fq[i]; rx_er = (i == er_at);
    end
    @(negedge clk); rx_dv = 0; rx_er = 0; rx_data = 8'h00;
    @(negedge clk);
    check(stat_valid == acc, req, "stat_valid (R8)", stat_valid, acc);
    if (acc) begin
      check(stat_len == 11'(len), "R8", "stat_len", stat_len, len);
      check(stat_type == typ, "R6", "stat_type", stat_type, typ);
      check(stat_vlan == vl, "R6", "stat_vlan", stat_vlan, vl);
      check(stat_bcast == bc, "R3", "stat_bcast", stat_bcast, bc);
      check(stat_mcast == mc, "R3", "stat_mcast", stat_mcast, mc);
    end
    @(negedge clk);
    check(stat_valid == 0, "R8", "stat_valid second cycle", stat_valid, 0);
    repeat (10) @(negedge clk);
    t = 0;
    while (eq.size() > 0 && t < 4000) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
    check(eq.size() == 0, "R7", "bytes not delivered", eq.size(), 0);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (eq.size() == 0) begin
        check(0, "R7", "unexpected output byte", out_data, 0);
      end else begin
        logic [7:0] eb;
        bit ef;
        eb = eq.pop_front();
        ef = eeof.pop_front();
        check(out_data == eb, "R7", "out_data", out_data, eb);
        check(out_eof == ef, "R7", "out_eof", out_eof, ef);
      end
    end else if (!rst) begin
      if (out_eof) check(0, "R7", "out_eof without out_valid", out_eof, 0);
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; rx_dv = 0; rx_er = 0; rx_data = 0;
    station_addr = STN; mcast_en = 0; promisc = 0;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_eof && !stat_valid, "R9", "outputs in reset",
          {out_valid, out_eof, stat_valid}, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    build(STN, 0, 16'h0800, 46, 0);   send(7, -1, "R4");  // exactly 64 bytes
    build(BCAST, 0, 16'h0806, 100, 0); send(7, -1, "R3");
    mcast_en = 1;
    build(MCAST, 0, 16'h86DD, 60, 0);  send(7, -1, "R3");
    mcast_en = 0;
    build(MCAST, 0, 16'h86DD, 60, 0);  send(7, -1, "R3");  // group bit, disabled
    build(OTHER, 0, 16'h0800, 50, 0);  send(7, -1, "R3");  // wrong unicast
    promisc = 1;
    build(OTHER, 0, 16'h0800, 50, 0);  send(7, -1, "R3");
    promisc = 0;
    build(STN, 0, 16'h0800, 80, 1);    send(7, -1, "R2");  // bad FCS
    build(STN, 0, 16'h0801, 81, 0);    send(7, -1, "R10"); // after a rewind
    build(STN, 0, 16'h0800, 70, 0);    send(7, 20, "R5");  // error strobe
    build(STN, 0, 16'h0800, 45, 0);    send(7, -1, "R4");  // 63 bytes
    build(STN, 0, 16'h0600, 1500, 0);  send(7, -1, "R4");  // 1518
    build(STN, 0, 16'h0600, 1501, 0);  send(7, -1, "R4");  // 1519
    build(STN, 0, 16'h0802, 64, 0);    send(7, -1, "R10");
    build(STN, 1, 16'h0800, 1500, 0);  send(7, -1, "R6");  // 1522 tagged
    build(STN, 1, 16'h0800, 1501, 0);  send(7, -1, "R6");  // 1523 tagged
    build(STN, 1, 16'h88CC, 42, 0);    send(7, -1, "R6");  // 64 tagged
    build(STN, 0, 16'h0800, 60, 0);    send(6, -1, "R1");  // short preamble
    build(STN, 0, 16'h0800, 61, 0);    send(10, -1, "R1"); // long preamble

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule